// File: doc/BRIEF.md
# Tone Digit Serial Readout

This block sits behind a tone decoder and hands a 4-bit decoded digit to an external controller over two wires. The decoder supplies the digit code and a steering flag that marks it as validated. The controller sees the steering flag on `steer_o`. It then toggles the asynchronous acknowledge line `ack_i` four times and reads one bit from `sdata_o` after each rising edge.

The serial output line has a second use. Whenever no digit transfer is running, it carries the call-progress cadence (envelope) flag. The controller can time supervisory tones on the same wire. Because tone bursts fall in the same band, this line may toggle while a digit tone is present.

The digit is captured on the first acknowledge rising edge, not on a separate load strobe. The acknowledge input is synchronised into the system clock domain before its edges are used. Powerdown forces both outputs low and abandons any transfer.

Top module: `tone_digit_serializer`

## Requirements
- R1: After reset, no transfer is in progress: `sdata_o` equals `cadence_i` and `steer_o` equals `steer_i` while powerdown is low.
- R2: With `steer_i` high, the first rising edge of `ack_i` loads `digit_i` into the shift register and starts a transfer. The load and the first bit on `sdata_o` take effect on the third rising clock edge after `ack_i` goes high (two synchroniser flops, then the state register).
- R3: Bits leave least significant first: bit 0 after the first acknowledge rise, and bits 1, 2, 3 after the second, third and fourth rises. Changes on `digit_i` after the load do not alter the bits sent.
- R4: When `ack_i` falls after the fourth pulse, `sdata_o` returns to `cadence_i` on the third clock edge after the fall. The bit counter never exceeds 4.
- R5: If `steer_i` goes low during a transfer, the transfer ends at the next clock edge and `sdata_o` shows `cadence_i`. The next transfer starts again from bit 0 of a freshly loaded digit.
- R6: Acknowledge pulses that arrive while `steer_i` is low load nothing and shift nothing. `sdata_o` keeps following `cadence_i`, and the first pulse after `steer_i` rises loads the digit present at that time.
- R7: While `pwrdn_i` is high, `sdata_o` and `steer_o` are both low and any transfer is abandoned. After powerdown ends, `sdata_o` follows `cadence_i`.
- R8: All 16 codes 0x0 to 0xF arrive intact over the serial line.
- R9: During a transfer `sdata_o` shows only the shifted bit and ignores `cadence_i`. Outside a transfer it follows `cadence_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwrdn_i | input | 1 | Powerdown; forces both outputs low |
| digit_i | input | 4 | Decoded tone digit code |
| steer_i | input | 1 | Digit-validated steering flag from the detector |
| cadence_i | input | 1 | Call-progress cadence (envelope) flag |
| ack_i | input | 1 | Asynchronous acknowledge clock from the controller; idles low |
| sdata_o | output | 1 | Serial digit data, or cadence when idle |
| steer_o | output | 1 | Steering flag presented to the controller |

## Verification
The assertions assume that `steer_i`, `cadence_i`, `pwrdn_i` and `digit_i` change synchronously to the system clock. They also assume that every acknowledge level lasts long enough for the two-flop synchroniser to see it, so no pulse is lost between counting edges. The stimulus changes every input on the falling clock edge. It holds each acknowledge level high or low for at least four clock periods, and it raises the next pulse only after the previous low phase has passed through the synchroniser.

// File: rtl/tds_pkg.sv
package tds_pkg;

    typedef enum logic [1:0] {
        SEL_CADENCE = 2'd0,
        SEL_SHIFT   = 2'd1,
        SEL_OFF     = 2'd2
    } sdata_sel_e;

    function automatic sdata_sel_e pick_source(input logic pwrdn, input logic active);
        if (pwrdn)       return SEL_OFF;
        else if (active) return SEL_SHIFT;
        else             return SEL_CADENCE;
    endfunction

endpackage

// File: rtl/tds_ack_sync.sv
module tds_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ack_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], ack_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/tds_shifter.sv
module tds_shifter #(
    parameter int DIGIT_W = 4,
    localparam int CNT_W  = $clog2(DIGIT_W + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               enable_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               active_o,
    output logic               bit_o,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGIT_W);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [DIGIT_W-1:0] sreg;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (rise_i) begin
            if (st_q.cnt == '0) begin
                st_d.sreg   = digit_i;
                st_d.cnt    = CNT_W'(1);
                st_d.active = 1'b1;
            end else if (st_q.cnt < LAST) begin
                st_d.sreg = st_q.sreg >> 1;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
        end else if (fall_i && st_q.cnt == LAST) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign bit_o    = st_q.sreg[0];
    assign cnt_o    = st_q.cnt;
endmodule

// File: rtl/tds_out_mux.sv
module tds_out_mux
    import tds_pkg::*;
(
    input  logic pwrdn_i,
    input  logic active_i,
    input  logic bit_i,
    input  logic cadence_i,
    input  logic steer_i,
    output logic sdata_o,
    output logic steer_o
);
    sdata_sel_e sel;

    always_comb begin
        sel = pick_source(pwrdn_i, active_i);
        unique case (sel)
            SEL_SHIFT:   sdata_o = bit_i;
            SEL_CADENCE: sdata_o = cadence_i;
            default:     sdata_o = 1'b0;
        endcase
        steer_o = steer_i & ~pwrdn_i;
    end
endmodule

// File: rtl/tone_digit_serializer.sv
module tone_digit_serializer #(
    parameter int DIGIT_W     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DIGIT_W + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pwrdn_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               steer_i,
    input  logic               cadence_i,
    input  logic               ack_i,
    output logic               sdata_o,
    output logic               steer_o
);
    logic             ack_rise, ack_fall;
    logic             xfer_active;
    logic             shift_bit;
    logic [CNT_W-1:0] bit_cnt;
    logic             shift_en;

    assign shift_en = steer_i & ~pwrdn_i;

    tds_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ack_i  (ack_i),
        .rise_o (ack_rise),
        .fall_o (ack_fall)
    );

    tds_shifter #(.DIGIT_W(DIGIT_W)) u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (shift_en),
        .rise_i   (ack_rise),
        .fall_i   (ack_fall),
        .digit_i  (digit_i),
        .active_o (xfer_active),
        .bit_o    (shift_bit),
        .cnt_o    (bit_cnt)
    );

    tds_out_mux u_mux (
        .pwrdn_i   (pwrdn_i),
        .active_i  (xfer_active),
        .bit_i     (shift_bit),
        .cadence_i (cadence_i),
        .steer_i   (steer_i),
        .sdata_o   (sdata_o),
        .steer_o   (steer_o)
    );
endmodule

// File: rtl/tone_digit_serializer_chk.sv
module tone_digit_serializer_chk #(
    parameter int DIGIT_W = 4,
    localparam int CNT_W  = $clog2(DIGIT_W + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pwrdn_i,
    input logic             steer_i,
    input logic             cadence_i,
    input logic             sdata_o,
    input logic             steer_o,
    input logic             xfer_active,
    input logic [CNT_W-1:0] bit_cnt
);
    assert_pwrdn_outputs_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_i |-> (!sdata_o && !steer_o));

    assert_pwrdn_aborts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_i |=> !xfer_active);

    assert_idle_follows_cadence_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwrdn_i && !xfer_active) |-> (sdata_o == cadence_i));

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_cnt <= CNT_W'(DIGIT_W));

    assert_steer_drop_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !steer_i |=> !xfer_active);

    assert_start_at_first_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xfer_active) |-> (bit_cnt == CNT_W'(1)));

    assert_steer_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwrdn_i |-> (steer_o == steer_i));
endmodule

bind tone_digit_serializer tone_digit_serializer_chk #(.DIGIT_W(DIGIT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwrdn_i     (pwrdn_i),
    .steer_i     (steer_i),
    .cadence_i   (cadence_i),
    .sdata_o     (sdata_o),
    .steer_o     (steer_o),
    .xfer_active (xfer_active),
    .bit_cnt     (bit_cnt)
);

// File: tb/tone_digit_serializer_tb.sv
module tone_digit_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       pwrdn = 1'b0;
    logic [3:0] digit = 4'h0;
    logic       steer = 1'b0;
    logic       cadence = 1'b0;
    logic       ack = 1'b0;
    logic       sdata, steer_out;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    tone_digit_serializer u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .pwrdn_i   (pwrdn),
        .digit_i   (digit),
        .steer_i   (steer),
        .cadence_i (cadence),
        .ack_i     (ack),
        .sdata_o   (sdata),
        .steer_o   (steer_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // raise ack and wait until the third clock edge has acted
    task automatic ack_up();
        @(negedge clk); ack = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ack_down();
        ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        cadence = 1'b1; steer = 1'b1; #1;
        chk("R1 cadence in reset", sdata, 1'b1);
        chk("R1 steer in reset", steer_out, 1'b1);
        @(negedge clk); rst_ni = 1'b1; cadence = 1'b0; steer = 1'b0;
        @(negedge clk);
        chk("R1 cadence after reset", sdata, 1'b0);
        chk("R1 steer after reset", steer_out, 1'b0);
    endtask

    task automatic t_transfer(input logic [3:0] d, input string req);
        @(negedge clk); steer = 1'b1; digit = d;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cadence = ~d[i]; ack = 1'b1;
            repeat (3) @(negedge clk);
            digit = ~d; // R3: later changes must not matter
            chk(req, sdata, d[i]);
            ack_down();
        end
        cadence = 1'b1; #1;
        chk("R4 cadence after fourth pulse", sdata, 1'b1);
        cadence = 1'b0; #1;
        chk("R4 cadence after fourth pulse", sdata, 1'b0);
        steer = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_all_codes();
        for (int d = 0; d < 16; d++) t_transfer(4'(d), "R8 code");
    endtask

    task automatic t_first_latch_timing();
        @(negedge clk); steer = 1'b1; digit = 4'h1; cadence = 1'b0;
        @(negedge clk); ack = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet latched after two edges", sdata, 1'b0);
        @(negedge clk);
        chk("R2 latched on third edge", sdata, 1'b1);
        ack_down();
        @(negedge clk); steer = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_steer_abort();
        @(negedge clk); steer = 1'b1; digit = 4'b0110; cadence = 1'b0;
        ack_up(); ack_down();
        ack_up(); chk("R3 second bit", sdata, 1'b1);
        ack_down();
        @(negedge clk); steer = 1'b0;
        @(negedge clk);
        chk("R5 abort shows cadence", sdata, 1'b0);
        cadence = 1'b1; #1;
        chk("R5 abort shows cadence", sdata, 1'b1);
        @(negedge clk); steer = 1'b1; digit = 4'b1001; cadence = 1'b0;
        ack_up(); chk("R5 restart at bit 0", sdata, 1'b1);
        ack_down();
        ack_up(); chk("R5 restart bit 1", sdata, 1'b0);
        ack_down();
        @(negedge clk); steer = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ignore_low_steer();
        @(negedge clk); steer = 1'b0; digit = 4'b1010;
        for (int i = 0; i < 3; i++) begin
            cadence = i[0];
            ack_up();
            chk("R6 ack ignored, cadence shown", sdata, i[0]);
            cadence = ~i[0]; #1;
            chk("R6 ack ignored, cadence shown", sdata, ~i[0]);
            ack_down();
        end
        @(negedge clk); steer = 1'b1; digit = 4'b0101; cadence = 1'b0;
        ack_up(); chk("R6 first pulse loads new digit", sdata, 1'b1);
        ack_down();
        cadence = 1'b1;
        ack_up(); chk("R6 second bit", sdata, 1'b0);
        ack_down();
        @(negedge clk); steer = 1'b0; cadence = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_powerdown();
        @(negedge clk); steer = 1'b1; cadence = 1'b1; pwrdn = 1'b1; #1;
        chk("R7 sdata low", sdata, 1'b0);
        chk("R7 steer low", steer_out, 1'b0);
        @(negedge clk); pwrdn = 1'b0; #1;
        chk("R7 cadence after powerdown", sdata, 1'b1);
        digit = 4'b0001; cadence = 1'b0;
        ack_up(); chk("R7 pre-abort bit", sdata, 1'b1);
        ack_down();
        @(negedge clk); pwrdn = 1'b1;
        @(negedge clk); pwrdn = 1'b0; #1;
        chk("R7 transfer abandoned", sdata, 1'b0);
        @(negedge clk); steer = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_first_latch_timing();
        t_transfer(4'b1011, "R3 lsb first");
        t_all_codes();
        t_steer_abort();
        t_ignore_low_steer();
        t_powerdown();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule